// File: doc/BRIEF.md
# Edge-Selectable Timer Capture Channel

This block is a single capture channel for a bank of timer channels that share one free-running counter. It watches an external input pin. When the pin makes a transition of the selected kind, the channel stores the counter value present at that moment in its capture register. Software can choose to trigger on rising transitions, on falling transitions, or on both. Each capture sets a flag that stays set until software clears it. When the interrupt enable is set, the flag also drives an interrupt request.

The raw pin first passes through a synchroniser. A stability filter follows, which rejects any level that does not persist for at least two system clocks. The edge detector works on the filtered level. Software sees that same filtered level in a status bit. When both edges are enabled, software reads this bit to tell which kind of transition caused the last capture.

Software reaches the channel through a small synchronous register port. The write side carries an address and a byte. The read side returns the addressed byte one clock after the address is presented.

Top module: `cap_channel`

## Requirements
- R1: With the rising-edge enable (control register, address 0, bit 0) set, a low-to-high transition of the filtered pin stores the counter value into the capture register. The capture register is read as byte 0 at address 2 and byte 1 at address 3.
- R2: With the falling-edge enable (address 0, bit 1) set, a high-to-low transition captures. With both enables set, either transition captures.
- R3: With both edge enables at 0, no transition changes the capture register or sets the flag.
- R4: Every capture sets the capture flag (status register, address 1, bit 0). The flag is sticky. It is cleared only by writing a byte with bit 0 = 1 to address 1.
- R5: The interrupt output is high exactly while the flag is 1 and the interrupt enable (address 0, bit 2) is 1. It follows the flag and the enable in the same cycle.
- R6: A pin level held for fewer than 2 clocks is ignored. A level held for 2 clocks or more is accepted as a transition.
- R7: Status bit 1 (address 1) returns the filtered pin level.
- R8: A new capture overwrites the capture register even while the flag is still set.
- R9: If a flag-clear write and a capture fall in the same cycle, the capture wins and the flag stays set.
- R10: Reset clears the capture register, the flag, all control bits and the interrupt output to 0.
- R11: The counter value stored is the one present at the 5th rising clock edge after the pin changes. Read data appears one clock after the read address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Raw asynchronous capture pin |
| count_i | input | CW (16) | Shared counter value |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW (3) | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | AW (3) | Register read address |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag-clear write that lands in the same clock as a capture. The write must arrive exactly at the fifth edge after a pin change. The bench does this by stepping the pin, the counter and the write strobe together in one loop on falling clock edges, so it knows which edge carries the capture. The pulse-width boundary gets the same treatment: single-clock and two-clock pulses are placed at exact clock counts. Random pin events and random control settings are then checked against bench-computed expectations.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int DW = 8;
  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_CAP0 = 3'd2;

  typedef struct packed {
    logic irq_en;
    logic fall_en;
    logic rise_en;
  } ctrl_t;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
  parameter int FILT_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  output logic lvl_o
);
  localparam int CNTW = $clog2(FILT_LEN + 1);

  logic            lvl_q;
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (din_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNTW'(FILT_LEN - 1)) begin
      lvl_q <= din_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;

  // R6: a new filtered level must have been present at the input for two cycles
  a_r6_stable_before_change: assert property (@(posedge clk) disable iff (rst)
    !$stable(lvl_q) |-> ($past(din_i) == lvl_q && $past(din_i, 2) == lvl_q));
endmodule

// File: rtl/cap_edge.sv
module cap_edge (
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl_i,
  input  logic [1:0] sel_i,
  output logic       fire_o
);
  logic lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl_i;
  end

  assign fire_o = (sel_i[0] & lvl_i & ~lvl_d) | (sel_i[1] & ~lvl_i & lvl_d);

  // R3: no selection means no capture
  a_r3_no_select_no_fire: assert property (@(posedge clk) disable iff (rst)
    (sel_i == 2'b00) |-> !fire_o);
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CW       = 16,
  parameter int AW       = 3,
  parameter int FILT_LEN = 2,
  parameter int SYNC_LEN = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pin_i,
  input  logic [CW-1:0] count_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  localparam int NB = CW / DW;

  logic          pin_sync, pin_lvl, fire;
  ctrl_t         ctrl_q, ctrl_d;
  logic          flag_q, flag_d, clr;
  logic [CW-1:0] cap_q;
  logic [DW-1:0] rd_mux;
  logic          irq_q;

  cap_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_sync));

  cap_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst(rst), .din_i(pin_sync), .lvl_o(pin_lvl));

  cap_edge u_edge (
    .clk(clk), .rst(rst), .lvl_i(pin_lvl),
    .sel_i({ctrl_q.fall_en, ctrl_q.rise_en}), .fire_o(fire));

  assign clr = wr_en_i && (wr_addr_i == AW'(ADDR_STAT)) && wr_data_i[0];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i && wr_addr_i == AW'(ADDR_CTRL)) ctrl_d = ctrl_t'(wr_data_i[2:0]);
    flag_d = fire ? 1'b1 : (clr ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      cap_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      flag_q <= flag_d;
      irq_q  <= flag_d & ctrl_d.irq_en;
      if (fire) cap_q <= count_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i == AW'(ADDR_CTRL)) rd_mux = DW'(ctrl_q);
    if (rd_addr_i == AW'(ADDR_STAT)) rd_mux = DW'({pin_lvl, flag_q});
    for (int k = 0; k < NB; k++) begin
      if (rd_addr_i == AW'(int'(ADDR_CAP0) + k)) rd_mux = cap_q[k*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_mux;
  end

  assign irq_o = irq_q;

  // R4: a capture always leaves the flag set
  a_r4_capture_sets_flag: assert property (@(posedge clk) disable iff (rst)
    fire |=> flag_q);
  // R4: the flag stays set unless software clears it
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  // R9: capture beats a simultaneous clear
  a_r9_capture_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (fire && clr) |=> flag_q);
  // R3: without a capture the stored value holds
  a_r3_hold_without_fire: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(cap_q));
  // R5: interrupt request only with flag set
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_q);
endmodule

// File: tb/tb_cap_channel.sv
module tb_cap_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        pin_i;
  logic [15:0] count_i;
  logic        wr_en_i;
  logic [2:0]  wr_addr_i;
  logic [7:0]  wr_data_i;
  logic [2:0]  rd_addr_i;
  logic [7:0]  rd_data_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_channel dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .count_i(count_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o));

  function automatic bit exp_fire(logic [2:0] c, bit rising);
    return rising ? c[0] : c[1];
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    rd_addr_i = a;
    @(negedge clk);
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic read_cap(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd2, lo);
    rd(3'd3, hi);
    v = {hi, lo};
  endtask

  // drive a pin change at this negedge; the counter steps base, base+1, ...
  task automatic pin_event(bit lvl, int hold, logic [15:0] base, bit clr4);
    for (int i = 0; i < 12; i++) begin
      if (i == 0) pin_i = lvl;
      if (i == hold) pin_i = ~lvl;
      count_i = base + 16'(i);
      wr_en_i = clr4 && (i == 4);
      wr_addr_i = 3'd1; wr_data_i = 8'h01;
      @(negedge clk);
    end
    wr_en_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [7:0]  s;
    logic [15:0] v, prev;
    bit          lvl;
    void'($urandom(32'h5eed));
    rst = 1; pin_i = 0; count_i = 0; wr_en_i = 0; wr_addr_i = 0;
    wr_data_i = 0; rd_addr_i = 0;
    repeat (4) @(negedge clk);
    rst = 0;

    // R10 reset state
    read_cap(v);  check("R10 capture", v, 0);
    rd(3'd1, s);  check("R10 flag", s[0], 0);
    rd(3'd0, s);  check("R10 ctrl", s[2:0], 0);
    check("R10 irq", irq_o, 0);

    // R3: no enables, rising edge ignored
    pin_event(1, 99, 16'h1111, 0);
    read_cap(v);  check("R3 capture", v, 0);
    rd(3'd1, s);  check("R3 flag", s[0], 0);
    check("R7 level high", s[1], 1);
    pin_event(0, 99, 16'h1111, 0);

    // R1/R11: rising capture value is counter at 5th edge
    wr(3'd0, 8'h05);
    pin_event(1, 99, 16'h2000, 0);
    read_cap(v);  check("R1 R11 rising capture", v, 16'h2004);
    rd(3'd1, s);  check("R4 flag set", s[0], 1);
    check("R5 irq with enable", irq_o, 1);
    wr(3'd0, 8'h01);
    @(negedge clk); check("R5 irq off with enable clear", irq_o, 0);

    // R2: falling ignored with rise only, then captured with fall enabled
    pin_event(0, 99, 16'h3000, 0);
    read_cap(v);  check("R2 fall ignored", v, 16'h2004);
    wr(3'd0, 8'h02);
    pin_event(1, 99, 16'h3100, 0);
    read_cap(v);  check("R2 rise ignored with fall only", v, 16'h2004);
    pin_event(0, 99, 16'h3200, 0);
    read_cap(v);  check("R2 falling capture", v, 16'h3204);

    // R4 sticky then cleared by write
    rd(3'd1, s);  check("R4 flag still set", s[0], 1);
    wr(3'd1, 8'h00);
    rd(3'd1, s);  check("R4 write 0 keeps flag", s[0], 1);
    wr(3'd1, 8'h01);
    rd(3'd1, s);  check("R4 write 1 clears flag", s[0], 0);

    // R6: one-clock pulse rejected, two-clock pulse accepted on both edges
    wr(3'd0, 8'h03);
    pin_event(1, 1, 16'h4000, 0);
    read_cap(v);  check("R6 short pulse", v, 16'h3204);
    rd(3'd1, s);  check("R6 short pulse flag", s[0], 0);
    pin_event(1, 2, 16'h5000, 0);
    read_cap(v);  check("R6 two-clock pulse both edges", v, 16'h5006);

    // R8: overwrite while flag is set
    pin_event(1, 99, 16'h6000, 0);
    read_cap(v);  check("R8 overwrite", v, 16'h6004);
    rd(3'd1, s);  check("R7 level after rise", s[1], 1);

    // R9: clear collides with capture at the 5th edge
    wr(3'd1, 8'h01);
    pin_event(0, 99, 16'h7000, 1);
    rd(3'd1, s);  check("R9 capture wins over clear", s[0], 1);
    read_cap(v);  check("R9 value", v, 16'h7004);

    // random mix
    lvl = 0;
    read_cap(prev);
    for (int it = 0; it < 40; it++) begin
      logic [2:0]  c;
      logic [15:0] base;
      int          hold;
      bit          fired;
      c    = 3'($urandom_range(0, 7));
      base = 16'($urandom);
      hold = ($urandom_range(0, 1) == 1) ? 1 : 99;
      wr(3'd1, 8'h01);
      wr(3'd0, {5'b0, c});
      pin_event(~lvl, hold, base, 0);
      fired = (hold != 1) && exp_fire(c, ~lvl);
      if (hold != 1) lvl = ~lvl;
      if (fired) prev = base + 16'd4;
      read_cap(v);  check("R1 R2 R3 R6 random capture", v, prev);
      rd(3'd1, s);
      check("R4 random flag", s[0], fired);
      check("R7 random level", s[1], lvl);
      check("R5 random irq", irq_o, fired & c[2]);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule